// File: doc/BRIEF.md
# Descriptor Ring Index Counter

This block keeps track of which buffer descriptor is current in a circular descriptor ring. Two registers describe the ring: a length register that holds the negated (two's complement) number of descriptors, and a position counter that lives in the same negative number space. The first descriptor is the one whose position equals the length register. The last descriptor always sits at the all-ones value (-1). Each advance strobe moves the counter one step. From the all-ones value it returns to the current length value.

An initialization pulse takes a descriptor count, stores its negation in the length register and places the counter on the first descriptor. While the stop flag is high, a host port can read and overwrite either register, which lets software reshape the ring. Outside that window, host accesses have no effect and reads return zero. For the descriptor logic, the block provides the raw position, a zero-based index and a last-descriptor flag.

Top module: `ring_idx_ctr`

## Requirements
- R1: After reset, the counter and the length register are both zero, and the host read data is zero.
- R2: On a cycle with `init_i` high, the length register takes the two's complement of `init_cnt_i` (a count of 0 means 2^W descriptors), and the counter takes that same value. This precedence applies over any host write and any advance in the same cycle.
- R3: On an advance that is accepted while the counter is not all-ones, the counter increases by exactly one, modulo 2^W.
- R4: On an advance that is accepted while the counter is all-ones, the counter loads the value the length register holds in that cycle.
- R5: `last_o` is high exactly when the counter equals all-ones.
- R6: `idx_o` equals the counter minus the length register, modulo 2^W.
- R7: While `stop_i` is high and `host_wr_i` is high, `host_sel_i`=0 writes `host_wdata_i` into the counter and `host_sel_i`=1 writes it into the length register. While `stop_i` is low, host writes leave both registers unchanged.
- R8: `host_rdata_o` shows the register that `host_sel_i` picks (0 = counter, 1 = length) when `stop_i` and `host_rd_i` are both high. It is zero in every other case.
- R9: While `stop_i` is high, `adv_i` is ignored.
- R10: A length value written by the host moves the wrap target. The next wrap from all-ones lands on the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_i | input | 1 | Stop flag; enables host access and blocks advancing |
| init_i | input | 1 | Initialization pulse |
| init_cnt_i | input | W | Descriptor count for initialization |
| adv_i | input | 1 | Advance to the next descriptor |
| host_wr_i | input | 1 | Host write strobe |
| host_rd_i | input | 1 | Host read enable |
| host_sel_i | input | 1 | Register select: 0 counter, 1 length |
| host_wdata_i | input | W | Host write data |
| host_rdata_o | output | W | Host read data |
| pos_o | output | W | Raw counter value |
| idx_o | output | W | Zero-based descriptor index |
| last_o | output | 1 | Current descriptor is the last in the ring |

## Verification
The bench builds the block with W=6. At that width every possible ring size, from 1 descriptor up to 64, can be initialized in turn and walked around its full circle and then some, with the counter, index and last flag checked after every step. The narrow width also places the all-ones wrap and the 2^W ring (count zero) within a few cycles of reach. Register access, precedence and wrap-point changes are exercised directly through the host port.

// File: rtl/ring_idx_pkg.sv
package ring_idx_pkg;
    typedef enum logic {
        SEL_POS = 1'b0,
        SEL_LEN = 1'b1
    } host_sel_e;
endpackage

// File: rtl/ring_len_reg.sv
module ring_len_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init_i,
    input  logic [W-1:0] init_cnt_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] len_o
);
    typedef struct packed {
        logic [W-1:0] len;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (init_i) begin
            s_d.len = '0 - init_cnt_i;
        end else if (wr_i) begin
            s_d.len = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign len_o = s_q.len;

    // R2: init stores the negated count
    a_r2_init_len: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (len_o == W'('0 - $past(init_cnt_i))));

    // R7: no write and no init means the length holds
    a_r7_len_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_i && !wr_i) |=> $stable(len_o));
endmodule

// File: rtl/ring_pos_ctr.sv
module ring_pos_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init_i,
    input  logic [W-1:0] init_cnt_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         adv_i,
    input  logic [W-1:0] len_i,
    output logic [W-1:0] pos_o,
    output logic [W-1:0] idx_o,
    output logic         last_o
);
    localparam logic [W-1:0] ALL_ONES = '1;

    typedef struct packed {
        logic [W-1:0] pos;
    } state_t;

    state_t s_d, s_q;
    logic   at_end;

    assign at_end = (s_q.pos == ALL_ONES);

    always_comb begin
        s_d = s_q;
        if (init_i) begin
            s_d.pos = '0 - init_cnt_i;
        end else if (wr_i) begin
            s_d.pos = wdata_i;
        end else if (adv_i) begin
            s_d.pos = at_end ? len_i : s_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pos_o  = s_q.pos;
    assign idx_o  = s_q.pos - len_i;
    assign last_o = at_end;

    // R3: a step off the last entry is a plain increment
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !init_i && !wr_i && pos_o != ALL_ONES) |=> (pos_o == W'($past(pos_o) + 1'b1)));

    // R4: a step from all-ones lands on the first descriptor
    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !init_i && !wr_i && pos_o == ALL_ONES) |=> (pos_o == $past(len_i)));

    // R2: init places the counter on the first descriptor
    a_r2_init_pos: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (idx_o == '0));

    // R9: idle cycles keep the position
    a_r9_pos_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !init_i && !wr_i) |=> $stable(pos_o));
endmodule

// File: rtl/ring_idx_ctr.sv
module ring_idx_ctr
    import ring_idx_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stop_i,
    input  logic         init_i,
    input  logic [W-1:0] init_cnt_i,
    input  logic         adv_i,
    input  logic         host_wr_i,
    input  logic         host_rd_i,
    input  logic         host_sel_i,
    input  logic [W-1:0] host_wdata_i,
    output logic [W-1:0] host_rdata_o,
    output logic [W-1:0] pos_o,
    output logic [W-1:0] idx_o,
    output logic         last_o
);
    logic         wr_pos, wr_len, adv_go;
    logic [W-1:0] len_q;
    logic [W-1:0] pos_q;

    assign wr_pos = stop_i && host_wr_i && (host_sel_e'(host_sel_i) == SEL_POS);
    assign wr_len = stop_i && host_wr_i && (host_sel_e'(host_sel_i) == SEL_LEN);
    assign adv_go = adv_i && !stop_i;

    ring_len_reg #(.W(W)) u_len (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_i     (init_i),
        .init_cnt_i (init_cnt_i),
        .wr_i       (wr_len),
        .wdata_i    (host_wdata_i),
        .len_o      (len_q)
    );

    ring_pos_ctr #(.W(W)) u_pos (
        .clk        (clk),
        .rst_n      (rst_n),
        .init_i     (init_i),
        .init_cnt_i (init_cnt_i),
        .wr_i       (wr_pos),
        .wdata_i    (host_wdata_i),
        .adv_i      (adv_go),
        .len_i      (len_q),
        .pos_o      (pos_q),
        .idx_o      (idx_o),
        .last_o     (last_o)
    );

    always_comb begin
        host_rdata_o = '0;
        if (stop_i && host_rd_i) begin
            host_rdata_o = (host_sel_e'(host_sel_i) == SEL_LEN) ? len_q : pos_q;
        end
    end

    assign pos_o = pos_q;

    // R8: reads are closed while running
    a_r8_rd_closed: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_i |-> (host_rdata_o == '0));

    // R9: while stopped, an advance alone moves nothing
    a_r9_stop_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !host_wr_i && !init_i) |=> $stable(pos_o));

    // R7: host writes while running leave the position alone
    a_r7_run_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_i && !adv_i && !init_i) |=> $stable(pos_o));
endmodule

// File: tb/ring_idx_ctr_bench.sv
module ring_idx_ctr_bench;
    localparam int W = 6;
    localparam logic [W-1:0] ONES = '1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         stop_i = 1'b0, init_i = 1'b0, adv_i = 1'b0;
    logic         host_wr_i = 1'b0, host_rd_i = 1'b0, host_sel_i = 1'b0;
    logic [W-1:0] init_cnt_i = '0, host_wdata_i = '0;
    logic [W-1:0] host_rdata_o, pos_o, idx_o;
    logic         last_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ring_idx_ctr #(.W(W)) u_ring_idx_ctr (
        .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .init_i(init_i),
        .init_cnt_i(init_cnt_i), .adv_i(adv_i), .host_wr_i(host_wr_i),
        .host_rd_i(host_rd_i), .host_sel_i(host_sel_i),
        .host_wdata_i(host_wdata_i), .host_rdata_o(host_rdata_o),
        .pos_o(pos_o), .idx_o(idx_o), .last_o(last_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        @(negedge clk);
        init_i = 0; adv_i = 0; host_wr_i = 0;
    endtask

    task automatic host_read(input bit sel, input string req, input int exp);
        host_sel_i = sel; host_rd_i = 1;
        #1 chk(req, host_rdata_o, exp);
        host_rd_i = 0;
    endtask

    task automatic host_write(input bit sel, input logic [W-1:0] v);
        host_sel_i = sel; host_wdata_i = v; host_wr_i = 1;
        tick();
    endtask

    task automatic check_state(input string req, input logic [W-1:0] p, input logic [W-1:0] l);
        chk(req, pos_o, p);
        chk("R6", idx_o, int'(W'(p - l)));
        chk("R5", last_o, int'(p == ONES));
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] elen, epos;
        @(negedge clk);
        // R1: reset state
        chk("R1", pos_o, 0);
        stop_i = 1;
        host_read(1'b1, "R1", 0);
        host_read(1'b0, "R1", 0);
        stop_i = 0;
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R2 R3 R4 R5 R6: every ring size, walked past one full lap
        for (int n = 0; n < (1 << W); n++) begin
            init_cnt_i = W'(n);
            init_i = 1;
            tick();
            elen = W'(0 - n);
            epos = elen;
            check_state("R2", epos, elen);
            for (int s = 0; s < ((n == 0) ? 66 : n + 2); s++) begin
                adv_i = 1;
                tick();
                epos = (epos == ONES) ? elen : W'(epos + 1);
                check_state((epos == elen) ? "R4" : "R3", epos, elen);
            end
        end

        // R7 R8: host access while stopped
        stop_i = 1;
        host_write(1'b0, 6'h05);
        host_write(1'b1, 6'h38);
        host_read(1'b0, "R8", 'h05);
        host_read(1'b1, "R8", 'h38);
        chk("R7", pos_o, 'h05);
        chk("R6", idx_o, int'(W'(6'h05 - 6'h38)));
        stop_i = 1; host_rd_i = 0; host_sel_i = 1;
        #1 chk("R8", host_rdata_o, 0);

        // R7 R8: writes while running are ignored, reads return zero
        stop_i = 0;
        host_write(1'b0, 6'h11);
        host_write(1'b1, 6'h22);
        host_read(1'b1, "R8", 0);
        host_read(1'b0, "R8", 0);
        chk("R7", pos_o, 'h05);
        stop_i = 1;
        host_read(1'b1, "R7", 'h38);

        // R9: advance blocked while stopped
        adv_i = 1;
        tick();
        chk("R9", pos_o, 'h05);

        // R10: new length moves the wrap target
        host_write(1'b1, 6'h3C);
        host_write(1'b0, 6'h3E);
        stop_i = 0;
        adv_i = 1; tick();
        chk("R10", pos_o, 'h3F);
        chk("R5", last_o, 1);
        adv_i = 1; tick();
        chk("R10", pos_o, 'h3C);
        chk("R6", idx_o, 0);

        // R2: init beats host write and advance
        stop_i = 1;
        init_cnt_i = 6'd3; init_i = 1;
        host_sel_i = 1; host_wdata_i = 6'h10; host_wr_i = 1;
        tick();
        host_read(1'b1, "R2", 'h3D);
        chk("R2", pos_o, 'h3D);
        stop_i = 0;
        init_cnt_i = 6'd7; init_i = 1; adv_i = 1;
        tick();
        chk("R2", pos_o, 'h39);
        chk("R2", idx_o, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule